// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that sits on an 8-bit register bus. It advances either on an instruction-rate tick (the system clock divided by four) or on rising edges of an external clock input. A prescaler divides the selected source by 1, 2, 4 or 8 before it reaches the counter. In counter mode the external clock either passes through a two-stage resynchronizer or is taken after a single capture flop. The single-flop path has one cycle less latency and is meant for a source that is already related to the system clock.

A run bit gates counting. A wrap from 0xFFFF to 0x0000 raises a sticky interrupt flag. A one-cycle pulse on the compare-trigger input zeroes the count. In wide access mode the high byte moves through a holding register. Reading the low byte captures the high byte at that instant, and a high-byte write waits in the holding register until the next low-byte write. Software therefore always sees and loads a coherent 16-bit value.

Register addresses: 0 is control, 1 is the count low byte, 2 is the count high byte (or its holding register), and 3 reads as zero.

Top module: `ptimer16`

## Requirements
- R1: After reset the control register, the count and the interrupt flag are all zero, and reads of addresses 0, 1 and 2 return 0x00.
- R2: With control bit0 (run) = 1 and bit1 (source) = 0, the count rises by exactly one every 4·N system clocks. N is 1, 2, 4 or 8 for prescale field bits[4:3] = 0, 1, 2, 3.
- R3: With bit1 = 1, the count rises once for every N rising edges of the external clock, with N taken from bits[4:3].
- R4: With bit2 (async) = 1, an external rising edge captured at clock edge k is counted at edge k+1. With bit2 = 0 it is counted at edge k+2, after two synchronizer stages.
- R5: With run = 0 the count holds its value unless it is written or cleared.
- R6: A wrap from 0xFFFF to 0x0000 sets control bit7 (irqFlag). Writing 0 to bit7 clears the flag, writing 1 has no effect, and a wrap in the same cycle as a clearing write leaves the flag set.
- R7: A high cycle on trigClr zeroes the count on the next edge. A count write in the same cycle takes priority.
- R8: With bit5 (wide) = 1, a read strobe at address 1 copies the live high byte into the holding register, and address 2 then reads that held value.
- R9: With wide = 1, a write to address 2 loads only the holding register. The next write to address 1 loads both bytes together and restarts the prescaler from zero.
- R10: With wide = 0, address 2 reads and writes the live high byte directly, and a write to address 1 changes only the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (side effect only on address 1) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from addressed register |
| extClk | input | 1 | External clock, asynchronous |
| trigClr | input | 1 | Compare-trigger clear pulse |
| irqFlag | output | 1 | Sticky overflow flag |

## Verification
Read data is combinational, so a register is sampled 1 ns after the bus address is driven and shows the state left by the previous edge. A write takes effect at the edge on which it is presented. An instruction tick advances the count on the edge where it occurs, so rates are checked as exact differences between two reads 400 or 800 edges apart, which does not depend on the divider's phase. The prescaler restart is checked as no change 28 edges after the low write and one increment by edge 32. External edges are checked at edge k+1 for the async path and at edge k+2 for the synchronized path. The flag is checked one edge after the wrap and after each control write.

// File: rtl/ptimerPkg.sv
package ptimerPkg;
  parameter int BUS_W = 8;
  parameter int CNT_W = 2 * BUS_W;
  parameter int PRE_W = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;

  typedef struct packed {
    logic             runEn;
    logic             extSel;
    logic             asyncSel;
    logic [PRE_W-1:0] preSel;
    logic             loadLow;
    logic             loadHigh;
    logic [CNT_W-1:0] loadVal;
    logic             clrPre;
  } strobeT;
endpackage

// File: rtl/ptimerCtrl.sv
module ptimerCtrl
  import ptimerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             ovfPulse,
  output strobeT           stb,
  output logic             irqFlag
);
  logic             runEn, extSel, asyncSel, wideMode;
  logic [PRE_W-1:0] preSel;
  logic [BUS_W-1:0] hiBuf;

  logic ctrlWr, lowWr, highWr, lowRd;
  assign ctrlWr = busWrEn && (busAddr == ADDR_CTRL);
  assign lowWr  = busWrEn && (busAddr == ADDR_LOW);
  assign highWr = busWrEn && (busAddr == ADDR_HIGH);
  assign lowRd  = busRdEn && (busAddr == ADDR_LOW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      extSel   <= 1'b0;
      asyncSel <= 1'b0;
      wideMode <= 1'b0;
      preSel   <= '0;
      irqFlag  <= 1'b0;
      hiBuf    <= '0;
    end else begin
      if (ctrlWr) begin
        runEn    <= busWrData[0];
        extSel   <= busWrData[1];
        asyncSel <= busWrData[2];
        preSel   <= busWrData[3 +: PRE_W];
        wideMode <= busWrData[5];
      end
      if (ovfPulse)
        irqFlag <= 1'b1;
      else if (ctrlWr && !busWrData[7])
        irqFlag <= 1'b0;
      if (wideMode && highWr)
        hiBuf <= busWrData;
      else if (wideMode && lowRd)
        hiBuf <= cntVal[CNT_W-1 -: BUS_W];
    end
  end

  always_comb begin
    stb          = '0;
    stb.runEn    = runEn;
    stb.extSel   = extSel;
    stb.asyncSel = asyncSel;
    stb.preSel   = preSel;
    if (lowWr) begin
      stb.loadLow  = 1'b1;
      stb.loadHigh = wideMode;
      stb.loadVal  = {hiBuf, busWrData};
      stb.clrPre   = 1'b1;
    end else if (highWr && !wideMode) begin
      stb.loadHigh = 1'b1;
      stb.loadVal  = {busWrData, {BUS_W{1'b0}}};
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdData = {irqFlag, 1'b0, wideMode, preSel, asyncSel, extSel, runEn};
      ADDR_LOW:  busRdData = cntVal[BUS_W-1:0];
      ADDR_HIGH: busRdData = wideMode ? hiBuf : cntVal[CNT_W-1 -: BUS_W];
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/ptimerDatapath.sv
module ptimerDatapath
  import ptimerPkg::*;
#(
  parameter int INST_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  logic             trigClr,
  input  strobeT           stb,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfPulse
);
  localparam int DIV_W = (INST_DIV > 1) ? $clog2(INST_DIV) : 1;
  localparam int PC_W  = (1 << PRE_W) - 1;

  logic [DIV_W-1:0]     divCnt;
  logic                 instTick;
  logic [SYNC_STAGES:0] syncChain;
  logic                 asyncEdge, syncEdge, srcTick;
  logic [PC_W-1:0]      preCnt, preMask;
  logic                 preHit, incTick, cntLoad;

  always_ff @(posedge clk) begin
    if (!rstN)
      divCnt <= '0;
    else if (divCnt == DIV_W'(INST_DIV - 1))
      divCnt <= '0;
    else
      divCnt <= divCnt + 1'b1;
  end
  assign instTick = (divCnt == DIV_W'(INST_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= extClk;
  end

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[s] <= 1'b0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign asyncEdge = syncChain[0] & ~syncChain[1];
  assign syncEdge  = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
  assign srcTick   = stb.extSel ? (stb.asyncSel ? asyncEdge : syncEdge) : instTick;

  assign preMask = ~({PC_W{1'b1}} << stb.preSel);
  assign preHit  = ((preCnt & preMask) == preMask);
  assign incTick = stb.runEn && srcTick && preHit;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrPre)
      preCnt <= '0;
    else if (stb.runEn && srcTick)
      preCnt <= preCnt + 1'b1;
  end

  assign cntLoad  = stb.loadLow || stb.loadHigh;
  assign ovfPulse = incTick && (cntVal == '1) && !cntLoad && !trigClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (cntLoad) begin
      if (stb.loadLow)  cntVal[BUS_W-1:0]       <= stb.loadVal[BUS_W-1:0];
      if (stb.loadHigh) cntVal[CNT_W-1 -: BUS_W] <= stb.loadVal[CNT_W-1 -: BUS_W];
    end else if (trigClr) begin
      cntVal <= '0;
    end else if (incTick) begin
      cntVal <= cntVal + 1'b1;
    end
  end
endmodule

// File: rtl/ptimer16.sv
module ptimer16
  import ptimerPkg::*;
#(
  parameter int INST_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData,
  input  logic             extClk,
  input  logic             trigClr,
  output logic             irqFlag
);
  strobeT           stb;
  logic [CNT_W-1:0] cntVal;
  logic             ovfPulse;
  logic             runEn;

  assign runEn = stb.runEn;

  ptimerCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .cntVal(cntVal), .ovfPulse(ovfPulse), .stb(stb), .irqFlag(irqFlag)
  );

  ptimerDatapath #(.INST_DIV(INST_DIV), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .extClk(extClk), .trigClr(trigClr),
    .stb(stb), .cntVal(cntVal), .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/ptimerChecker.sv
module ptimerChecker
  import ptimerPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWrEn,
  input logic [BUS_W-1:0] busWrData,
  input logic             trigClr,
  input logic             irqFlag,
  input logic [CNT_W-1:0] cntVal,
  input logic             ovfPulse,
  input logic             runEn
);
  logic cntWr, flagClrWr;
  assign cntWr     = busWrEn && (busAddr == ADDR_LOW || busAddr == ADDR_HIGH);
  assign flagClrWr = busWrEn && (busAddr == ADDR_CTRL) && !busWrData[7];

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (trigClr && !cntWr) |=> (cntVal == '0)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWr && !trigClr) |=> $stable(cntVal)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && !trigClr) |=> (cntVal == $past(cntVal) || cntVal == $past(cntVal) + 1'b1)); // R2

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> irqFlag); // R6

  AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> (cntVal == '0)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClrWr) |=> irqFlag); // R6
endmodule

bind ptimer16 ptimerChecker chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .trigClr(trigClr), .irqFlag(irqFlag),
  .cntVal(cntVal), .ovfPulse(ovfPulse), .runEn(runEn)
);

// File: tb/ptimer16_tb_top.sv
`timescale 1ns/1ps
module ptimer16_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       extClk = 1'b0, trigClr = 1'b0;
  logic       irqFlag;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ptimer16 dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .extClk(extClk), .trigClr(trigClr), .irqFlag(irqFlag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic read16(output logic [15:0] v);
    @(negedge clk);
    busAddr = 2'd1; busRdEn = 1'b1; #1; v[7:0] = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0; busAddr = 2'd2; #1; v[15:8] = busRdData;
  endtask

  task automatic wr16(logic [15:0] v);
    wr(2'd2, v[15:8]);
    wr(2'd1, v[7:0]);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (10) @(posedge clk);
  endtask

  task automatic tReset();
    logic [7:0] d;
    @(negedge clk);
    peek(2'd0, d); chk("R1 ctrl", d, 8'h00);
    peek(2'd1, d); chk("R1 low", d, 8'h00);
    peek(2'd2, d); chk("R1 high", d, 8'h00);
    chk("R1 flag", irqFlag, 0);
  endtask

  task automatic tWideWrite();
    logic [7:0] d; logic [15:0] v;
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h34);
    wr(2'd0, 8'h00);
    @(negedge clk); peek(2'd2, d); chk("R9 high write buffered only", d, 8'h00);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h56);
    read16(v); chk("R9 low write commits both", v, 16'h3456);
    repeat (100) @(posedge clk);
    read16(v); chk("R5 run off holds", v, 16'h3456);
  endtask

  task automatic tTrig();
    logic [15:0] v;
    @(negedge clk); trigClr = 1'b1;
    @(negedge clk); trigClr = 1'b0;
    read16(v); chk("R7 trigger clears", v, 16'h0000);
  endtask

  task automatic tRate(logic [7:0] ctrl, int gap, int expDelta, string tag);
    logic [15:0] a, b;
    wr(2'd0, ctrl);
    repeat (50) @(posedge clk);
    read16(a);
    repeat (gap - 1) @(posedge clk);
    read16(b);
    chk(tag, int'(b - a), expDelta);
  endtask

  task automatic tPreClear();
    logic [7:0] d;
    wr(2'd0, 8'h39);
    repeat (37) @(posedge clk);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h10);
    repeat (27) @(posedge clk); #1;
    peek(2'd1, d); chk("R9 prescaler restarted, no step yet", d, 8'h10);
    repeat (4) @(posedge clk); #1;
    peek(2'd1, d); chk("R9 prescaler restarted, one step", d, 8'h11);
  endtask

  task automatic tExt(logic [7:0] ctrl, int n, int expCnt, string tag);
    logic [15:0] v;
    wr(2'd0, ctrl);
    wr16(16'h0000);
    pulses(n);
    read16(v); chk(tag, v, expCnt);
  endtask

  task automatic tLatency(logic asyncSel);
    logic [7:0] d;
    wr(2'd0, asyncSel ? 8'h07 : 8'h03);
    wr16(16'h0000);
    repeat (5) @(posedge clk);
    @(negedge clk); extClk = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    peek(2'd1, d); chk("R4 count one edge after capture", d, asyncSel ? 1 : 0);
    @(posedge clk); #1;
    peek(2'd1, d); chk("R4 count two edges after capture", d, 1);
    @(negedge clk); extClk = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  task automatic tOverflow();
    logic [15:0] v;
    wr(2'd0, 8'h20);
    wr16(16'hFFF8);
    chk("R6 flag clear before wrap", irqFlag, 0);
    wr(2'd0, 8'h21);
    repeat (60) @(posedge clk); #1;
    chk("R6 wrap sets flag", irqFlag, 1);
    read16(v); chk("R6 count wrapped high byte", v[15:8], 8'h00);
    wr(2'd0, 8'hA1);
    chk("R6 writing 1 keeps flag", irqFlag, 1);
    repeat (5) @(posedge clk); #1;
    chk("R6 flag sticky", irqFlag, 1);
    wr(2'd0, 8'h21);
    chk("R6 writing 0 clears flag", irqFlag, 0);
    wr(2'd0, 8'h20);
  endtask

  task automatic tWideRead();
    logic [7:0] d;
    wr(2'd0, 8'h20);
    wr16(16'h01F0);
    wr(2'd0, 8'h21);
    @(negedge clk);
    busAddr = 2'd1; busRdEn = 1'b1;
    @(posedge clk); #1; busRdEn = 1'b0;
    repeat (80) @(posedge clk); #1;
    peek(2'd2, d); chk("R8 high read returns held byte", d, 8'h01);
    wr(2'd0, 8'h01);
    @(negedge clk); peek(2'd2, d); chk("R10 narrow high read is live", d, 8'h02);
  endtask

  task automatic tNarrow();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h22);
    wr(2'd2, 8'h7F);
    @(negedge clk);
    peek(2'd2, d); chk("R10 narrow high write direct", d, 8'h7F);
    peek(2'd1, d); chk("R10 low kept", d, 8'h22);
    wr(2'd1, 8'h44);
    @(negedge clk);
    peek(2'd2, d); chk("R10 low write leaves high", d, 8'h7F);
    peek(2'd1, d); chk("R10 low write value", d, 8'h44);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tWideWrite();
    tTrig();
    tRate(8'h21, 400, 100, "R2 timer divide 1");
    tRate(8'h39, 800, 25, "R2 timer divide 8");
    tPreClear();
    tExt(8'h2B, 10, 5, "R3 external divide 2 sync");
    tExt(8'h37, 8, 2, "R3 external divide 4 async");
    tLatency(1'b1);
    tLatency(1'b0);
    tOverflow();
    tWideRead();
    tNarrow();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule